// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM that is sixteen bits wide, has an 18-bit word address, a pair of chip selects (one active low, one active high) and two active-low byte-lane enables. The host issues one request at a time through a valid/ready handshake. Each request carries a read/write flag, a word address, write data and a two-bit lane mask. The block then produces the pin waveform for a single memory cycle and reports completion with a one-cycle done pulse. For a read, that pulse comes with the returned data.

All memory timing comes from nanosecond parameters and the clock period. Each interval becomes a cycle count: the time divided by the period, rounded up, with a floor of one cycle. The shared data bus appears as three separate signals (data out, data in and a drive enable), so that the pad ring can build the tri-state buffer. After every read, the block waits through a fixed quiet period before it accepts new work. During that period the RAM releases the bus, and no write can start driving against it.

Top module: `sram_byte_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory is deselected: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_be_n`=2'b11, `mem_dq_oe`=0, and `rsp_done`=0 after reset.
- R2: An accepted read with a nonzero mask enables the chip (`mem_cs1_n`=0, `mem_cs2`=1), drives `mem_oe_n` low with `mem_we_n` high, and drives `mem_be_n[i]` low exactly when `req_mask[i]` is 1. Lane 0 carries bits 7:0 and lane 1 carries bits 15:8. These pins hold for N_RD cycles, where N_RD is the largest of the ceil-converted read-cycle (70 ns), access (70 ns) and output-enable (35 ns) times. This is 7 cycles at a 10 ns clock.
- R3: A read is sampled from `mem_dq_in` on its last active cycle. In the following cycle `rsp_done` pulses and `rsp_rdata` shows the selected lanes, with every unselected lane reading zero. `rsp_rdata` keeps its value until the next read completes.
- R4: An accepted write enables the chip, drives `mem_we_n` low, and sets `mem_be_n` from the mask, `mem_addr` from the address and `mem_dq_out` from the write data. These hold stable for N_WR cycles, the largest of the ceil-converted write pulse (55 ns), select/address-to-end (60 ns), data setup (30 ns) and write cycle (70 ns) times: 7 cycles at 10 ns. All strobes are then released on the same edge, and `rsp_done` pulses one cycle later.
- R5: A write changes only the byte lanes selected by its mask. The other lane of the stored word keeps its previous value.
- R6: `mem_dq_oe` is high only while `mem_we_n` is low. It rises and falls on the same edges as the write strobe.
- R7: After a read releases `mem_oe_n`, the block stays busy for N_HZ = ceil(25 ns / period) further cycles (3 at 10 ns). `mem_dq_oe` therefore never rises sooner than N_HZ cycles after `mem_oe_n` returns high.
- R8: A request with `req_mask`=2'b00 is accepted and completes with `rsp_done` in the next cycle. It starts no memory cycle, and `req_ready` stays high.
- R9: `req_ready` is low from acceptance until the cycle ends: N_RD+N_HZ cycles for a read and N_WR cycles for a write. Requests presented while `req_ready` is low are ignored.
- R10: `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 18 | RAM address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low lane enables |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_in | input | 16 | Data read from the bus |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
The properties take the host payload into account only on the accepting edge. They place no constraint on `mem_dq_in`. Their timing limits are derived from the same nanosecond parameters as the design, so the clock period must be a positive number of nanoseconds. The stimulus changes inputs only on falling edges. While the controller is busy, it deliberately presents junk requests to check that they are ignored. It attaches a behavioural RAM that returns a distinct filler pattern on deselected lanes and when the bus is not enabled, so a lane that is wrongly gated shows up in the read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Round a time up to whole clock cycles, never below one cycle.
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_TURN  = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [NB-1:0] lane_en,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] rdata
);
  localparam int LANE_W = DW / NB;

  logic [NB-1:0][LANE_W-1:0] q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= '0;
      else if (capture)
        q[g] <= lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign rdata = q;
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_HZ_NS = 25,
  parameter int T_WP_NS = 55,
  parameter int T_CW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int T_WC_NS = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int N_RD  = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                              ns2cyc(T_OE_NS, CLK_NS));
  localparam int N_WR  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                              imax(ns2cyc(T_DW_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS)));
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int N_MAX = imax(imax(N_RD, N_WR), N_HZ);
  localparam int CNT_W = $clog2(N_MAX + 1);

  seq_state_e          state;
  logic                tmr_load;
  logic [CNT_W-1:0]    tmr_val;
  logic                tmr_done;
  logic                cap_now;
  logic [LANES-1:0]    lane_sel;
  logic                start_op;

  assign req_ready = (state == ST_IDLE);
  assign start_op  = req_ready && req_valid && (req_mask != '0);
  assign cap_now   = (state == ST_READ) && tmr_done;

  // Timer reload points: start of a memory cycle, and start of bus turnaround.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_op) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CNT_W'(N_WR - 1) : CNT_W'(N_RD - 1);
    end else if (cap_now) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(N_HZ - 1);
    end
  end

  sram_cycle_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sram_read_capture #(.DW(DATA_W), .NB(LANES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture (cap_now),
    .lane_en (lane_sel),
    .bus_in  (mem_dq_in),
    .rdata   (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rsp_done   <= 1'b0;
      mem_addr   <= '0;
      mem_cs1_n  <= 1'b1;
      mem_cs2    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      lane_sel   <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_mask == '0) begin
              rsp_done <= 1'b1;
            end else begin
              mem_addr  <= req_addr;
              mem_be_n  <= ~req_mask;
              lane_sel  <= req_mask;
              mem_cs1_n <= 1'b0;
              mem_cs2   <= 1'b1;
              if (req_write) begin
                mem_we_n   <= 1'b0;
                mem_dq_out <= req_wdata;
                mem_dq_oe  <= 1'b1;
                state      <= ST_WRITE;
              end else begin
                mem_oe_n <= 1'b0;
                state    <= ST_READ;
              end
            end
          end
        end
        ST_READ: begin
          if (tmr_done) begin
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            rsp_done  <= 1'b1;
            state     <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (tmr_done) state <= ST_IDLE;
        end
        ST_WRITE: begin
          if (tmr_done) begin
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            rsp_done  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_HZ_NS = 25,
  parameter int T_WP_NS = 55,
  parameter int T_CW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int T_WC_NS = 70
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_mask,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam int N_RD = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                             ns2cyc(T_OE_NS, CLK_NS));
  localparam int N_WR = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                             imax(ns2cyc(T_DW_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS)));
  localparam int N_HZ = ns2cyc(T_HZ_NS, CLK_NS);

  logic [7:0] oe_low_run, we_low_run, oe_high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_low_run  <= '0;
      we_low_run  <= '0;
      oe_high_run <= 8'hFF;
    end else begin
      oe_low_run  <= !mem_oe_n ? ((oe_low_run == 8'hFF) ? oe_low_run : oe_low_run + 1'b1) : 8'd0;
      we_low_run  <= !mem_we_n ? ((we_low_run == 8'hFF) ? we_low_run : we_low_run + 1'b1) : 8'd0;
      oe_high_run <= mem_oe_n ? ((oe_high_run == 8'hFF) ? oe_high_run : oe_high_run + 1'b1) : 8'd0;
    end
  end

  // R1: idle means a fully deselected, undriven memory interface
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n &&
                   (mem_be_n == '1) && !mem_dq_oe));

  // R2: read strobe stays low at least N_RD cycles
  a_r2_read_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_low_run >= N_RD));

  // R4: write strobe stays low at least N_WR cycles
  a_r4_write_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_run >= N_WR));

  // R4: address, lanes, selects and data hold still during the write strobe
  a_r4_write_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_out) &&
       $stable(mem_cs1_n) && $stable(mem_cs2)));

  // R6: bus drive only inside a write strobe with the chip selected
  a_r6_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs1_n && mem_cs2));

  // R7: turnaround before driving after a read
  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_high_run >= N_HZ));

  // R8: empty mask completes next cycle with no memory activity
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_mask == '0)) |=>
      (rsp_done && req_ready && mem_cs1_n && mem_we_n && mem_oe_n));

  // R10: never read and write strobe together
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

endmodule

bind sram_byte_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES), .CLK_NS (CLK_NS),
  .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS),
  .T_WP_NS(T_WP_NS), .T_CW_NS(T_CW_NS), .T_DW_NS(T_DW_NS), .T_WC_NS(T_WC_NS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .rsp_done(rsp_done), .mem_addr(mem_addr),
  .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  function automatic int cdiv(input int t);
    int c;
    c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NRD = mx(mx(cdiv(70), cdiv(70)), cdiv(35));
  localparam int NWR = mx(mx(cdiv(55), cdiv(60)), mx(cdiv(30), cdiv(70)));
  localparam int NHZ = cdiv(25);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask  = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_byte_ctrl #(.CLK_NS(CLK_PERIOD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // ---------------- behavioural RAM attached to the pins ----------------
  logic [15:0] ram_data [1024];
  logic [17:0] ram_tag  [1024];
  bit          ram_vld  [1024];
  logic [15:0] ram_word;

  initial for (int i = 0; i < 1024; i++) begin
    ram_data[i] = '0; ram_tag[i] = '0; ram_vld[i] = 0;
  end

  always_comb begin
    if (ram_vld[mem_addr[9:0]] && ram_tag[mem_addr[9:0]] == mem_addr)
      ram_word = ram_data[mem_addr[9:0]];
    else
      ram_word = 16'h0000;
    if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_be_n[1] ? 8'hA5 : ram_word[15:8],
                   mem_be_n[0] ? 8'hA5 : ram_word[7:0]};
    else
      mem_dq_in = 16'h5A5A;
  end

  logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  logic [17:0] p_addr;
  logic [1:0]  p_be_n;
  logic [15:0] p_dq;
  int we_run = 0, oe_run = 0, oe_hi_run = 100;

  always @(negedge clk) begin
    if (!rst) begin
      // write ends when the strobe returns high: commit selected lanes
      if (!p_we_n && mem_we_n) begin
        chk(we_run >= NWR, "R4 write strobe width", we_run, NWR);
        if (ram_tag[p_addr[9:0]] != p_addr || !ram_vld[p_addr[9:0]]) begin
          ram_data[p_addr[9:0]] = '0;
        end
        ram_tag[p_addr[9:0]] = p_addr;
        ram_vld[p_addr[9:0]] = 1;
        if (!p_be_n[0]) ram_data[p_addr[9:0]][7:0]  = p_dq[7:0];
        if (!p_be_n[1]) ram_data[p_addr[9:0]][15:8] = p_dq[15:8];
      end
      if (!p_oe_n && mem_oe_n)
        chk(oe_run >= NRD, "R2 read strobe width", oe_run, NRD);
      oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
      if (!p_dq_oe && mem_dq_oe)
        chk(oe_hi_run > NHZ, "R7 turnaround before drive", oe_hi_run, NHZ + 1);
      we_run = !mem_we_n ? we_run + 1 : 0;
      oe_run = !mem_oe_n ? oe_run + 1 : 0;
      chk(!(!mem_oe_n && !mem_we_n), "R10 strobes exclusive", {mem_oe_n, mem_we_n}, 2'b11);
      chk(!mem_dq_oe || !mem_we_n, "R6 drive only in write", {mem_dq_oe, mem_we_n}, 2'b10);
    end
    p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
    p_addr = mem_addr; p_be_n = mem_be_n; p_dq = mem_dq_out;
  end

  // ---------------- cycle-level reference model ----------------
  logic [15:0] ref_mem [int];
  int          left = 0;
  bit          kind_wr = 0;
  logic [17:0] pend_addr;
  logic [1:0]  pend_mask;
  bit          exp_done = 0;
  logic [15:0] exp_rdata = '0;

  function automatic logic [15:0] ref_rd(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      left = 0; exp_done = 0; exp_rdata = '0;
    end else begin
      exp_done = 0;
      if (left == 0) begin
        if (req_valid) begin
          if (req_mask == 2'b00) exp_done = 1;
          else if (req_write) begin
            logic [15:0] w;
            w = ref_rd(req_addr);
            if (req_mask[0]) w[7:0]  = req_wdata[7:0];
            if (req_mask[1]) w[15:8] = req_wdata[15:8];
            ref_mem[int'(req_addr)] = w;
            left = NWR; kind_wr = 1;
          end else begin
            left = NRD + NHZ; kind_wr = 0;
            pend_addr = req_addr; pend_mask = req_mask;
          end
        end
      end else begin
        left--;
        if (kind_wr && left == 0) exp_done = 1;
        if (!kind_wr && left == NHZ) begin
          logic [15:0] r;
          r = ref_rd(pend_addr);
          exp_done  = 1;
          exp_rdata = {pend_mask[1] ? r[15:8] : 8'h00, pend_mask[0] ? r[7:0] : 8'h00};
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(req_ready == (left == 0), "R9 ready follows busy window", req_ready, left == 0);
      chk(rsp_done == exp_done, "R3/R4/R8 done pulse", rsp_done, exp_done);
      if (exp_done)
        chk(rsp_rdata == exp_rdata, "R3 R5 read data lanes", rsp_rdata, exp_rdata);
      if (req_ready)
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R1 idle pins deselected",
            {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 7'b1011110);
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] seed = 32'h1234_5678;

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) begin
      // junk while busy must be ignored (R9)
      seed = seed * 32'd1103515245 + 32'd12345;
      req_valid = seed[20]; req_write = seed[21];
      req_addr = seed[29:12]; req_wdata = seed[15:0]; req_mask = 2'b11;
      @(negedge clk);
    end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_done, "R1 reset handshake", {req_ready, rsp_done}, 2'b10);
    chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R1 reset pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe},
        7'b1011110);
    rst = 0;

    issue(1, 18'h00010, 16'h1234, 2'b11);       // R4 full word
    issue(0, 18'h00010, 16'h0000, 2'b11);       // R2 R3 full read
    issue(1, 18'h00010, 16'hFFAB, 2'b01);       // R5 low lane only
    issue(0, 18'h00010, 16'h0000, 2'b11);
    issue(1, 18'h00010, 16'hCDFF, 2'b10);       // R5 high lane only
    issue(0, 18'h00010, 16'h0000, 2'b10);       // R3 upper only
    issue(0, 18'h00010, 16'h0000, 2'b01);       // R3 lower only
    issue(1, 18'h00010, 16'hFFFF, 2'b00);       // R8 empty mask
    issue(0, 18'h00010, 16'h0000, 2'b00);       // R8 empty read
    issue(0, 18'h00010, 16'h0000, 2'b11);
    issue(1, 18'h00000, 16'h0F0F, 2'b11);       // boundary addresses
    issue(1, 18'h3FFFF, 16'hF0F0, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b11);
    issue(1, 18'h00000, 16'h5566, 2'b11);       // R7 read then write
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b11);
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      issue(seed[31], {8'h00, seed[9:8], seed[7:0]}, seed[27:12], seed[29:28]);
    end
    repeat (NRD + NHZ + 4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
    summary();
    $finish;
  end
endmodule